// File: doc/BRIEF.md
# Inertial Sensor Hub SPI Packet Controller

This block is the state machine between an SPI byte shifter and an inertial sensor hub. After reset it waits for the hub to finish booting, which the hub signals by pulling its active-low data-ready line. It then sends two feature-enable command packets on the control channel. The first turns on the orientation quaternion report and the second turns on the calibrated gyroscope report. The bytes of both packets come from an internal lookup indexed by packet and byte position. Once the hub answers with a new data-ready, the controller enters its data loop.

In the data loop, every low level on the data-ready line starts one read transaction. Chip select is lowered and bytes are clocked out with a zero transmit byte. The four-byte header is captured to learn the packet length and channel. Payload bytes are decoded one at a time as they arrive; the packet is never stored. A complete quaternion or gyroscope sample is copied to the outputs in one step and flagged with a one-cycle strobe. Chip select is released when the byte count reaches the header length.

State names are BOOT, INIT_SETUP, INIT_SEND, INIT_WAIT, INIT_GAP, DONE_CHECK, WAIT_DATA, RX_SETUP, RX_SEND and RX_WAIT. The transitions are:
- BOOT to INIT_SETUP on data-ready.
- INIT_SETUP to INIT_SEND unconditionally.
- INIT_SEND to INIT_WAIT when the shifter is idle.
- INIT_WAIT to INIT_SEND on a done pulse, or to INIT_GAP on the done pulse of the last command byte.
- INIT_GAP to INIT_SETUP when another command is left, otherwise to DONE_CHECK.
- DONE_CHECK to WAIT_DATA on data-ready.
- WAIT_DATA to RX_SETUP on data-ready.
- RX_SETUP to RX_SEND unconditionally.
- RX_SEND to RX_WAIT when the shifter is idle.
- RX_WAIT to RX_SEND on a done pulse, or to WAIT_DATA on the done pulse of the last byte of the packet.

Top module: `hub_link_ctrl`

## Requirements
- R1: While reset is applied and right after it, cs_n is 1, spi_start is 0, every quaternion and gyro output is 0 and both strobes are 0.
- R2: While int_n has stayed high since reset, spi_start is never raised and cs_n stays 1.
- R3: After int_n first goes low, the controller sends two command packets of 21 bytes each. Each packet is inside its own cs_n low window. cs_n is low for at least one cycle before the first spi_start of a window, and every spi_start happens with cs_n low.
- R4: Command packet n (n = 0, 1) has these bytes. Offsets 0 and 1 hold the total length 21, little-endian. Offset 2 holds control channel 2. Offset 3 holds sequence n. Offset 4 holds 0xFD. Offset 5 holds the report ID: 0x05 for n = 0, 0x02 for n = 1. Offsets 9 to 12 hold the report interval in microseconds, little-endian: 10000 for n = 0, 5000 for n = 1. Every other offset up to 20 holds 0.
- R5: After the second command packet, no transfer starts while int_n stays high. The controller leaves that check only once int_n is low.
- R6: Each read transaction starts from a low int_n and transmits only 0x00 bytes. spi_start is raised only while spi_busy is 0.
- R7: A read transaction clocks exactly L bytes, where L is the 15-bit length from header bytes 0 and 1. When L is 4 or less, including 0, it ends right after the 4 header bytes. cs_n then returns to 1.
- R8: A packet on data channel 3 whose payload byte 0 is 0x05 loads the outputs from payload offsets 4 to 11. The order is quat_x, quat_y, quat_z, quat_w, each 16-bit little-endian. quat_valid pulses for exactly one cycle.
- R9: A packet on data channel 3 whose payload byte 0 is 0x02 loads gyro_x, gyro_y and gyro_z from payload offsets 4 to 9, little-endian. gyro_valid pulses for exactly one cycle.
- R10: A payload on another channel, or with another report ID, gives no strobe. All quaternion and gyro outputs keep their values.
- R11: A quaternion packet whose length ends before the last component byte gives no strobe and leaves the outputs unchanged.
- R12: Bit 7 of header byte 1 is a continuation flag and is excluded from the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_n | input | 1 | Hub data-ready, active low, asynchronous |
| cs_n | output | 1 | Hub chip select, active low |
| spi_start | output | 1 | Request one byte exchange from the shifter |
| spi_tx | output | 8 | Byte to transmit, 0x00 during reads |
| spi_busy | input | 1 | Shifter is exchanging a byte |
| spi_done | input | 1 | One-cycle pulse, spi_rx holds the received byte |
| spi_rx | input | 8 | Byte received from the hub |
| quat_w | output | 16 | Quaternion real part |
| quat_x | output | 16 | Quaternion i part |
| quat_y | output | 16 | Quaternion j part |
| quat_z | output | 16 | Quaternion k part |
| quat_valid | output | 1 | New quaternion on the outputs |
| gyro_x | output | 16 | Angular rate, x |
| gyro_y | output | 16 | Angular rate, y |
| gyro_z | output | 16 | Angular rate, z |
| gyro_valid | output | 1 | New gyro sample on the outputs |

## Verification
A wrong header capture or a wrong byte counter shows up as the wrong number of bytes inside a cs_n window. That is visible when chip select rises at the end of the same packet. A wrong report ID or channel latch shows up as a missing or extra strobe, or as an output that changes without one, within the cycle after the packet's last payload byte. An error in the command lookup or packet sequencing appears as a wrong transmitted byte at its exact offset during initialization. It can also appear as a wrong count of chip-select windows before the controller goes quiet to wait for data-ready.

// File: rtl/hub_pkg.sv
package hub_pkg;

    localparam int HDR_BYTES = 4;
    localparam int CMD_PAY   = 17;
    localparam int CMD_LEN   = HDR_BYTES + CMD_PAY;

    localparam logic [7:0] OP_SET_FEATURE = 8'hFD;
    localparam logic [7:0] RPT_ROTVEC     = 8'h05;
    localparam logic [7:0] RPT_GYRO       = 8'h02;

    // payload offsets of the first component byte and of the shadowed bytes
    localparam int COMP_BASE  = 4;
    localparam int SHADOW_LEN = 8;
    localparam int QUAT_LAST  = COMP_BASE + 7;
    localparam int GYRO_LAST  = COMP_BASE + 5;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_INIT_SETUP,
        ST_INIT_SEND,
        ST_INIT_WAIT,
        ST_INIT_GAP,
        ST_DONE_CHECK,
        ST_WAIT_DATA,
        ST_RX_SETUP,
        ST_RX_SEND,
        ST_RX_WAIT
    } hub_state_e;

endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] stage_q;
            for (genvar s = 0; s < STAGES; s++) begin : g_stage
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stage_q[s] <= 1'b1;
                    end else if (s == 0) begin
                        stage_q[s] <= d;
                    end else begin
                        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                    end
                end
            end
            assign q = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/hub_cmd_table.sv
module hub_cmd_table
    import hub_pkg::*;
#(
    parameter int          IDX_W     = 15,
    parameter int          SEL_W     = 1,
    parameter logic [31:0] QUAT_US   = 32'd10000,
    parameter logic [31:0] GYRO_US   = 32'd5000,
    parameter logic [7:0]  CTRL_CHAN = 8'd2
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       cmd_byte
);

    // Byte lookup for the feature-enable packets (R4)
    function automatic logic [7:0] lookup(input logic [SEL_W-1:0] s,
                                          input logic [IDX_W-1:0] i);
        logic [31:0] period;
        logic [7:0]  rid;
        logic [7:0]  b;
        period = (s == '0) ? QUAT_US : GYRO_US;
        rid    = (s == '0) ? RPT_ROTVEC : RPT_GYRO;
        case (int'(i))
            0:       b = 8'(CMD_LEN);
            1:       b = 8'(CMD_LEN >> 8);
            2:       b = CTRL_CHAN;
            3:       b = 8'(s);
            4:       b = OP_SET_FEATURE;
            5:       b = rid;
            9:       b = period[7:0];
            10:      b = period[15:8];
            11:      b = period[23:16];
            12:      b = period[31:24];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    assign cmd_byte = lookup(sel, idx);

endmodule

// File: rtl/hub_report_decoder.sv
module hub_report_decoder
    import hub_pkg::*;
#(
    parameter int IDX_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_stb,
    input  logic [IDX_W-1:0] pay_idx,
    input  logic [7:0]       pay_byte,
    output logic [15:0]      quat_w,
    output logic [15:0]      quat_x,
    output logic [15:0]      quat_y,
    output logic [15:0]      quat_z,
    output logic             quat_valid,
    output logic [15:0]      gyro_x,
    output logic [15:0]      gyro_y,
    output logic [15:0]      gyro_z,
    output logic             gyro_valid
);

    logic [7:0] rpt_id;
    logic [7:0] shadow [SHADOW_LEN];
    logic       quat_fire;
    logic       gyro_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_id <= 8'h00;
        end else if (byte_stb && pay_idx == '0) begin
            rpt_id <= pay_byte;
        end
    end

    // one capture register per component byte
    generate
        for (genvar g = 0; g < SHADOW_LEN; g++) begin : g_shadow
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shadow[g] <= 8'h00;
                end else if (byte_stb && pay_idx == IDX_W'(COMP_BASE + g)) begin
                    shadow[g] <= pay_byte;
                end
            end
        end
    endgenerate

    // a sample completes only on its final byte (R8, R9, R11)
    assign quat_fire = byte_stb && (rpt_id == RPT_ROTVEC) && (pay_idx == IDX_W'(QUAT_LAST));
    assign gyro_fire = byte_stb && (rpt_id == RPT_GYRO)   && (pay_idx == IDX_W'(GYRO_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quat_x     <= 16'h0000;
            quat_y     <= 16'h0000;
            quat_z     <= 16'h0000;
            quat_w     <= 16'h0000;
            quat_valid <= 1'b0;
        end else begin
            quat_valid <= quat_fire;
            if (quat_fire) begin
                quat_x <= {shadow[1], shadow[0]};
                quat_y <= {shadow[3], shadow[2]};
                quat_z <= {shadow[5], shadow[4]};
                quat_w <= {pay_byte,  shadow[6]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gyro_x     <= 16'h0000;
            gyro_y     <= 16'h0000;
            gyro_z     <= 16'h0000;
            gyro_valid <= 1'b0;
        end else begin
            gyro_valid <= gyro_fire;
            if (gyro_fire) begin
                gyro_x <= {shadow[1], shadow[0]};
                gyro_y <= {shadow[3], shadow[2]};
                gyro_z <= {pay_byte,  shadow[4]};
            end
        end
    end

endmodule

// File: rtl/hub_link_ctrl.sv
module hub_link_ctrl
    import hub_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          LEN_W       = 15,
    parameter int          NUM_CMDS    = 2,
    parameter logic [31:0] QUAT_US     = 32'd10000,
    parameter logic [31:0] GYRO_US     = 32'd5000,
    parameter logic [7:0]  CTRL_CHAN   = 8'd2,
    parameter logic [7:0]  DATA_CHAN   = 8'd3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        int_n,
    output logic        cs_n,
    output logic        spi_start,
    output logic [7:0]  spi_tx,
    input  logic        spi_busy,
    input  logic        spi_done,
    input  logic [7:0]  spi_rx,
    output logic [15:0] quat_w,
    output logic [15:0] quat_x,
    output logic [15:0] quat_y,
    output logic [15:0] quat_z,
    output logic        quat_valid,
    output logic [15:0] gyro_x,
    output logic [15:0] gyro_y,
    output logic [15:0] gyro_z,
    output logic        gyro_valid
);

    localparam int SEL_W = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1;

    hub_state_e        state;
    hub_state_e        nxt;
    logic              int_q;
    logic              int_act;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W:0]    cnt_inc;
    logic [SEL_W-1:0]  cmd_sel;
    logic [7:0]        len_lo;
    logic [LEN_W-1:0]  pkt_len;
    logic [7:0]        chan;
    logic [7:0]        cmd_byte;
    logic              last_cmd_byte;
    logic              last_cmd;
    logic              rx_last;
    logic              pay_stb;
    logic [LEN_W-1:0]  pay_idx;

    hub_sync #(.STAGES(SYNC_STAGES)) u_int_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (int_n),
        .q     (int_q)
    );

    assign int_act = ~int_q;

    hub_cmd_table #(
        .IDX_W     (LEN_W),
        .SEL_W     (SEL_W),
        .QUAT_US   (QUAT_US),
        .GYRO_US   (GYRO_US),
        .CTRL_CHAN (CTRL_CHAN)
    ) u_cmd_table (
        .sel      (cmd_sel),
        .idx      (cnt),
        .cmd_byte (cmd_byte)
    );

    assign cnt_inc       = {1'b0, cnt} + 1'b1;
    assign last_cmd_byte = (cnt == LEN_W'(CMD_LEN - 1));
    assign last_cmd      = (cmd_sel == SEL_W'(NUM_CMDS - 1));
    // R7: stop once the counted bytes reach the header length, never before the header
    assign rx_last       = (cnt >= LEN_W'(HDR_BYTES - 1)) && (cnt_inc >= {1'b0, pkt_len});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:       if (int_act) nxt = ST_INIT_SETUP;           // R2
            ST_INIT_SETUP: nxt = ST_INIT_SEND;                          // R3
            ST_INIT_SEND:  if (!spi_busy) nxt = ST_INIT_WAIT;
            ST_INIT_WAIT:  if (spi_done) nxt = last_cmd_byte ? ST_INIT_GAP : ST_INIT_SEND;
            ST_INIT_GAP:   nxt = last_cmd ? ST_DONE_CHECK : ST_INIT_SETUP;
            ST_DONE_CHECK: if (int_act) nxt = ST_WAIT_DATA;            // R5
            ST_WAIT_DATA:  if (int_act) nxt = ST_RX_SETUP;             // R6
            ST_RX_SETUP:   nxt = ST_RX_SEND;
            ST_RX_SEND:    if (!spi_busy) nxt = ST_RX_WAIT;
            ST_RX_WAIT:    if (spi_done) nxt = rx_last ? ST_WAIT_DATA : ST_RX_SEND;
            default:       nxt = ST_BOOT;
        endcase
    end

    // Counters and header capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cmd_sel <= '0;
            len_lo  <= 8'h00;
            pkt_len <= '0;
            chan    <= 8'h00;
        end else begin
            case (state)
                ST_BOOT: begin
                    cnt     <= '0;
                    cmd_sel <= '0;
                end
                ST_INIT_WAIT: begin
                    if (spi_done) cnt <= cnt + 1'b1;
                end
                ST_INIT_GAP: begin
                    cnt <= '0;
                    if (!last_cmd) cmd_sel <= cmd_sel + 1'b1;
                end
                ST_WAIT_DATA: begin
                    cnt <= '0;
                end
                ST_RX_WAIT: begin
                    if (spi_done) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LEN_W'(0)) len_lo <= spi_rx;
                        // R12: continuation flag dropped from the length
                        if (cnt == LEN_W'(1)) pkt_len <= LEN_W'({spi_rx[6:0], len_lo});
                        if (cnt == LEN_W'(2)) chan <= spi_rx;
                    end
                end
                default: ;
            endcase
        end
    end

    // Payload bytes go straight to the decoder (R8, R9, R10)
    assign pay_stb = (state == ST_RX_WAIT) && spi_done &&
                     (cnt >= LEN_W'(HDR_BYTES)) && (chan == DATA_CHAN);
    assign pay_idx = cnt - LEN_W'(HDR_BYTES);

    // Outputs
    always_comb begin
        cs_n      = 1'b1;
        spi_start = 1'b0;
        spi_tx    = 8'h00;
        unique case (state)
            ST_INIT_SETUP, ST_INIT_WAIT, ST_RX_SETUP, ST_RX_WAIT: begin
                cs_n = 1'b0;
            end
            ST_INIT_SEND: begin
                cs_n      = 1'b0;
                spi_start = ~spi_busy;
                spi_tx    = cmd_byte;
            end
            ST_RX_SEND: begin
                cs_n      = 1'b0;
                spi_start = ~spi_busy;
            end
            default: ;
        endcase
    end

    hub_report_decoder #(.IDX_W(LEN_W)) u_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_stb   (pay_stb),
        .pay_idx    (pay_idx),
        .pay_byte   (spi_rx),
        .quat_w     (quat_w),
        .quat_x     (quat_x),
        .quat_y     (quat_y),
        .quat_z     (quat_z),
        .quat_valid (quat_valid),
        .gyro_x     (gyro_x),
        .gyro_y     (gyro_y),
        .gyro_z     (gyro_z),
        .gyro_valid (gyro_valid)
    );

endmodule

// File: rtl/hub_link_ctrl_chk.sv
module hub_link_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        int_n,
    input logic        cs_n,
    input logic        spi_start,
    input logic        spi_busy,
    input logic [63:0] quat_all,
    input logic        quat_valid,
    input logic [47:0] gyro_all,
    input logic        gyro_valid
);

    logic int_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_seen <= 1'b0;
        end else if (!int_n) begin
            int_seen <= 1'b1;
        end
    end

    // R2
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_seen |-> (cs_n && !spi_start));

    // R3
    cs_low_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |-> !cs_n);

    // R3
    setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !spi_start);

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |-> !spi_busy);

    // R8
    quat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quat_valid |=> !quat_valid);

    // R9
    gyro_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gyro_valid |=> !gyro_valid);

    // R10
    quat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !quat_valid |-> $stable(quat_all));

    // R10
    gyro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gyro_valid |-> $stable(gyro_all));

endmodule

bind hub_link_ctrl hub_link_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_n      (int_n),
    .cs_n       (cs_n),
    .spi_start  (spi_start),
    .spi_busy   (spi_busy),
    .quat_all   ({quat_w, quat_x, quat_y, quat_z}),
    .quat_valid (quat_valid),
    .gyro_all   ({gyro_x, gyro_y, gyro_z}),
    .gyro_valid (gyro_valid)
);

// File: tb/tb_hub_link_ctrl.sv
`timescale 1ns/1ps
module tb_hub_link_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_n = 1'b1;
    logic        cs_n;
    logic        spi_start;
    logic [7:0]  spi_tx;
    logic        spi_busy = 1'b0;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rx = 8'h00;
    logic [15:0] quat_w, quat_x, quat_y, quat_z;
    logic [15:0] gyro_x, gyro_y, gyro_z;
    logic        quat_valid, gyro_valid;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] rx_mem [64];
    logic [7:0] tx_mem [64];
    int tx_ptr = 0;
    int rx_ptr = 0;
    int qv_cnt = 0;
    int gv_cnt = 0;
    int cs_falls = 0;
    int setup_bad = 0;
    logic prev_cs = 1'b1;

    always #2 clk = ~clk;

    hub_link_ctrl dut (
        .clk(clk), .rst_n(rst_n), .int_n(int_n), .cs_n(cs_n),
        .spi_start(spi_start), .spi_tx(spi_tx), .spi_busy(spi_busy),
        .spi_done(spi_done), .spi_rx(spi_rx),
        .quat_w(quat_w), .quat_x(quat_x), .quat_y(quat_y), .quat_z(quat_z),
        .quat_valid(quat_valid),
        .gyro_x(gyro_x), .gyro_y(gyro_y), .gyro_z(gyro_z),
        .gyro_valid(gyro_valid)
    );

    // Byte shifter model: start -> busy for three cycles -> done pulse
    initial begin
        forever begin
            @(posedge clk);
            if (spi_start && !spi_busy) begin
                if (tx_ptr < 64) tx_mem[tx_ptr] <= spi_tx;
                tx_ptr   <= tx_ptr + 1;
                spi_busy <= 1'b1;
                repeat (2) @(posedge clk);
                spi_rx   <= (rx_ptr < 64) ? rx_mem[rx_ptr] : 8'h00;
                rx_ptr   <= rx_ptr + 1;
                spi_done <= 1'b1;
                @(posedge clk);
                spi_done <= 1'b0;
                spi_busy <= 1'b0;
            end
        end
    end

    // Port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (quat_valid) qv_cnt++;
            if (gyro_valid) gv_cnt++;
            if (!cs_n && prev_cs) cs_falls++;
            if (spi_start && (cs_n || prev_cs)) setup_bad++;
        end
        prev_cs = cs_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        nchk++;
        if (act !== exp_v) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input int p, input int i);
        logic [31:0] per;
        per = (p == 0) ? 32'd10000 : 32'd5000;
        case (i)
            0: return 8'd21;
            2: return 8'd2;
            3: return 8'(p);
            4: return 8'hFD;
            5: return (p == 0) ? 8'h05 : 8'h02;
            9: return per[7:0];
            10: return per[15:8];
            11: return per[23:16];
            12: return per[31:24];
            default: return 8'h00;
        endcase
    endfunction

    task automatic clr_rx();
        for (int i = 0; i < 64; i++) rx_mem[i] = 8'h00;
    endtask

    task automatic hdr(input int len, input bit cont, input int ch, input int seq);
        rx_mem[0] = 8'(len);
        rx_mem[1] = {cont, 7'(len >> 8)};
        rx_mem[2] = 8'(ch);
        rx_mem[3] = 8'(seq);
    endtask

    task automatic put16(input int at, input logic [15:0] v);
        rx_mem[at]   = v[7:0];
        rx_mem[at+1] = v[15:8];
    endtask

    task automatic xfer();
        tx_ptr = 0;
        rx_ptr = 0;
        int_n = 1'b0;
        @(negedge cs_n);
        int_n = 1'b1;
        @(posedge cs_n);
        repeat (8) @(negedge clk);
    endtask

    task automatic chk_tx_zero(input string tag);
        int nz;
        nz = 0;
        for (int i = 0; i < tx_ptr && i < 64; i++) if (tx_mem[i] != 8'h00) nz++;
        chk(tag, nz, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", cs_n, 1);
        chk("R1 spi_start in reset", spi_start, 0);
        chk("R1 quat outputs", {quat_w, quat_x}, 0);
        chk("R1 quat outputs yz", {quat_y, quat_z}, 0);
        chk("R1 gyro outputs", {gyro_x, gyro_y, gyro_z} == 48'd0, 1);
        chk("R1 strobes", {quat_valid, gyro_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n after reset", cs_n, 1);
    endtask

    task automatic t_boot_hold();
        repeat (40) @(negedge clk);
        chk("R2 no transfer while booting", tx_ptr, 0);
        chk("R2 cs_n high while booting", cs_n, 1);
    endtask

    task automatic t_init();
        int bad;
        tx_ptr = 0;
        rx_ptr = 0;
        clr_rx();
        int_n = 1'b0;
        @(negedge cs_n);
        int_n = 1'b1;
        wait (tx_ptr == 42);
        @(posedge cs_n);
        repeat (10) @(negedge clk);
        chk("R3 two command windows", cs_falls, 2);
        chk("R3 setup cycle before start", setup_bad, 0);
        chk("R3 total command bytes", tx_ptr, 42);
        bad = 0;
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 21; i++)
                if (tx_mem[p*21 + i] !== exp_cmd(p, i)) begin
                    bad++;
                    $display("FAIL R4 packet %0d byte %0d actual=%h expected=%h",
                             p, i, tx_mem[p*21 + i], exp_cmd(p, i));
                end
        nchk++;
        if (bad != 0) nfail++;
    endtask

    task automatic t_done_check();
        repeat (40) @(negedge clk);
        chk("R5 no read while int_n high", tx_ptr, 42);
        chk("R5 cs_n high in done check", cs_n, 1);
        clr_rx();
        hdr(8, 0, 2, 0);
        rx_mem[4] = 8'hF1;
        xfer();
        chk("R5 response read after int_n low", tx_ptr, 8);
        chk_tx_zero("R6 read bytes are zero");
        chk("R10 control channel no strobe", qv_cnt + gv_cnt, 0);
    endtask

    task automatic t_quat();
        int q0, c0;
        clr_rx();
        hdr(18, 1, 3, 7);
        rx_mem[4] = 8'h05;
        put16(8, 16'h1234); put16(10, 16'hFFFE);
        put16(12, 16'h8000); put16(14, 16'h7FFF);
        put16(16, 16'h0003);
        q0 = qv_cnt; c0 = cs_falls;
        xfer();
        chk("R12 length with continuation flag", tx_ptr, 18);
        chk("R7 one cs window", cs_falls - c0, 1);
        chk_tx_zero("R6 read bytes are zero");
        chk("R8 quat_valid pulses", qv_cnt - q0, 1);
        chk("R8 quat_x", quat_x, 16'h1234);
        chk("R8 quat_y", quat_y, 16'hFFFE);
        chk("R8 quat_z", quat_z, 16'h8000);
        chk("R8 quat_w", quat_w, 16'h7FFF);
    endtask

    task automatic t_gyro();
        int g0, q0;
        clr_rx();
        hdr(14, 0, 3, 1);
        rx_mem[4] = 8'h02;
        put16(8, 16'h0102); put16(10, 16'hFF00); put16(12, 16'h0040);
        g0 = gv_cnt; q0 = qv_cnt;
        xfer();
        chk("R7 gyro packet byte count", tx_ptr, 14);
        chk("R9 gyro_valid pulses", gv_cnt - g0, 1);
        chk("R9 no quat strobe", qv_cnt - q0, 0);
        chk("R9 gyro_x", gyro_x, 16'h0102);
        chk("R9 gyro_y", gyro_y, 16'hFF00);
        chk("R9 gyro_z", gyro_z, 16'h0040);
    endtask

    task automatic t_other_id();
        int s0;
        clr_rx();
        hdr(14, 0, 3, 2);
        rx_mem[4] = 8'h01;
        put16(8, 16'hAAAA); put16(10, 16'hBBBB); put16(12, 16'hCCCC);
        s0 = qv_cnt + gv_cnt;
        xfer();
        chk("R10 other id byte count", tx_ptr, 14);
        chk("R10 other id no strobe", qv_cnt + gv_cnt - s0, 0);
        chk("R10 gyro held", gyro_x, 16'h0102);
        chk("R10 quat held", quat_w, 16'h7FFF);
    endtask

    task automatic t_other_chan();
        int s0;
        clr_rx();
        hdr(18, 0, 2, 3);
        rx_mem[4] = 8'h05;
        put16(8, 16'h5555); put16(10, 16'h6666);
        put16(12, 16'h7777); put16(14, 16'h1111);
        s0 = qv_cnt + gv_cnt;
        xfer();
        chk("R10 other channel byte count", tx_ptr, 18);
        chk("R10 other channel no strobe", qv_cnt + gv_cnt - s0, 0);
        chk("R10 quat held on other channel", quat_x, 16'h1234);
    endtask

    task automatic t_zero_len();
        int s0;
        clr_rx();
        hdr(0, 0, 3, 0);
        rx_mem[4] = 8'h05;
        s0 = qv_cnt + gv_cnt;
        xfer();
        chk("R7 zero length ends after header", tx_ptr, 4);
        chk("R7 zero length no strobe", qv_cnt + gv_cnt - s0, 0);
        chk("R7 cs_n released", cs_n, 1);
    endtask

    task automatic t_trunc();
        int q0;
        clr_rx();
        hdr(15, 0, 3, 4);
        rx_mem[4] = 8'h05;
        put16(8, 16'h0A0A); put16(10, 16'h0B0B);
        put16(12, 16'h0C0C); put16(14, 16'h0D0D);
        q0 = qv_cnt;
        xfer();
        chk("R11 truncated byte count", tx_ptr, 15);
        chk("R11 truncated no strobe", qv_cnt - q0, 0);
        chk("R11 quat_x held", quat_x, 16'h1234);
        chk("R11 quat_w held", quat_w, 16'h7FFF);
    endtask

    task automatic t_quat2();
        int q0;
        clr_rx();
        hdr(18, 0, 3, 5);
        rx_mem[4] = 8'h05;
        put16(8, 16'h0001); put16(10, 16'h0002);
        put16(12, 16'hFFFF); put16(14, 16'h4000);
        q0 = qv_cnt;
        xfer();
        chk("R8 second quat strobe", qv_cnt - q0, 1);
        chk("R8 second quat_x", quat_x, 16'h0001);
        chk("R8 second quat_y", quat_y, 16'h0002);
        chk("R8 second quat_z", quat_z, 16'hFFFF);
        chk("R8 second quat_w", quat_w, 16'h4000);
        chk("R9 gyro held across quat", gyro_z, 16'h0040);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        clr_rx();
        t_reset();
        t_boot_hold();
        t_init();
        t_done_check();
        t_quat();
        t_gyro();
        t_other_id();
        t_other_chan();
        t_zero_len();
        t_trunc();
        t_quat2();
        chk("R3 no start outside setup order", setup_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule